// File: doc/BRIEF.md
# Discrete-Time Cellular Network Processing Element

This block is a single processing element of a digital, discrete-time cellular network. It is meant to be tiled into an image-sized array. It holds one binary input pixel of its own, a signed multi-bit state and a one-bit output. In each iteration it builds five weighted contributions, one at a time: one for each of its four nearest neighbours and one for itself. It then folds them, together with a bias constant, into a new state. The output is taken from the sign of that state.

The weights are not stored in the element. They arrive on global coefficient buses that the whole array shares. External control walks every element through three phases with single-cycle strobes: contribution generation, accumulation and output update. A strobe that arrives outside its phase is discarded. Edge elements mark missing neighbours with a per-side mask, and those neighbours read a shared boundary value instead.

Top module: `cnn_pe`

## Requirements
- R1: After reset, state_out is 0 and y_out is 0, and the next generation strobe is taken as the north contribution.
- R2: A binary value of 0 stands for +1 and a value of 1 stands for -1. The coefficients are COEF_W-bit two's complement. Each contribution equals tmpl_a times the neighbour output value plus tmpl_b times the neighbour input value.
- R3: Accepted generation strobes are taken in the slot order north, east, south, west, self. Neighbour bit 0 is north, 1 is east, 2 is south and 3 is west. Each strobe uses the tmpl_a and tmpl_b values present in the cycle it is accepted.
- R4: When edge_mask bit i is 1, both the output and the input of neighbour i are replaced by bnd_val.
- R5: An acc_en accepted after all five contributions loads state_out, one cycle later, with the sum of the five contributions plus bias.
- R6: The new state saturates to the signed STATE_W range: -128 to 127 at the defaults.
- R7: A strobe outside its phase changes nothing. Such strobes are: acc_en or out_en during generation, a sixth gen_en after the five contributions, and out_en before accumulation.
- R8: An out_en accepted after accumulation sets y_out to the state MSB one cycle later. The next iteration then begins at the north slot.
- R9: The self contribution uses the element's own y_out and pix_in.
- R10: Only one iteration step is taken per cycle. A second acc_en in the same iteration is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | 1 | Own binary input pixel |
| nbr_y | input | 4 | Neighbour outputs (bit 0 N, 1 E, 2 S, 3 W) |
| nbr_u | input | 4 | Neighbour inputs (same bit order) |
| edge_mask | input | 4 | 1 marks a neighbour beyond the array edge |
| bnd_val | input | 1 | Value supplied for masked neighbours |
| tmpl_a | input | COEF_W | Global feedback coefficient for the current slot |
| tmpl_b | input | COEF_W | Global input coefficient for the current slot |
| bias | input | STATE_W | Signed constant added at accumulation |
| gen_en | input | 1 | Generate the contribution for the current slot |
| acc_en | input | 1 | Accumulate the five contributions into the state |
| out_en | input | 1 | Update the output from the state sign |
| y_out | output | 1 | Binary output of the element |
| state_out | output | STATE_W | Signed state |

## Verification
On every cycle the assertions check that at most one phase step is taken. They also check that the state moves only after an accepted accumulation and the output only after an accepted update. Further checks are that the output copies the state sign, that the slot index advances by one per contribution, and that an acc_en that is not accepted leaves the state alone. The arithmetic itself can only be shown by the bench's scenarios. These cover the sign mapping, the slot order, boundary substitution, saturation at both ends, use of the element's own output and pixel, and the discarding of strobes that are out of phase. For each of these the bench compares the state and output with values computed from the rules above.

// File: rtl/cnn_pe_pkg.sv
package cnn_pe_pkg;
   localparam int unsigned NUM_NBR = 4;
   localparam int unsigned NUM_SLOTS = NUM_NBR + 1;
   localparam int unsigned SLOT_IDX_W = $clog2(NUM_SLOTS);
   typedef enum logic [1:0] {
      PH_GEN = 2'd0,
      PH_ACC = 2'd1,
      PH_OUT = 2'd2
   } pe_phase_t;
endpackage

// File: rtl/cnn_pe_seq.sv
module cnn_pe_seq
   import cnn_pe_pkg::*;
#(
   parameter int unsigned SLOTS  = NUM_SLOTS,
   parameter int unsigned SLOT_W = SLOT_IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gen_en,
   input  logic              acc_en,
   input  logic              out_en,
   output logic [SLOT_W-1:0] slot,
   output logic              gen_take,
   output logic              acc_take,
   output logic              out_take
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

   pe_phase_t phase_q;

   always_comb begin
      gen_take = gen_en && (phase_q == PH_GEN);
      acc_take = acc_en && (phase_q == PH_ACC);
      out_take = out_en && (phase_q == PH_OUT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_GEN;
         slot    <= '0;
      end else if (gen_take) begin
         if (slot == LAST) phase_q <= PH_ACC;
         else              slot    <= slot + 1'b1;
      end else if (acc_take) begin
         phase_q <= PH_OUT;
      end else if (out_take) begin
         phase_q <= PH_GEN;
         slot    <= '0;
      end
   end
endmodule

// File: rtl/cnn_pe_psum.sv
module cnn_pe_psum #(
   parameter int unsigned COEF_W = 4,
   parameter int unsigned PS_W   = COEF_W + 2
) (
   input  logic [COEF_W-1:0] coef_a,
   input  logic [COEF_W-1:0] coef_b,
   input  logic              y_bit,
   input  logic              u_bit,
   output logic [PS_W-1:0]   psum
);
   logic [PS_W-1:0] a_ext, b_ext, a_term, b_term;

   always_comb begin
      a_ext  = {{(PS_W-COEF_W){coef_a[COEF_W-1]}}, coef_a};
      b_ext  = {{(PS_W-COEF_W){coef_b[COEF_W-1]}}, coef_b};
      // a binary 1 carries weight -1, a binary 0 weight +1
      a_term = y_bit ? (~a_ext + 1'b1) : a_ext;
      b_term = u_bit ? (~b_ext + 1'b1) : b_ext;
      psum   = a_term + b_term;
   end
endmodule

// File: rtl/cnn_pe_acc.sv
module cnn_pe_acc #(
   parameter int unsigned PS_W     = 6,
   parameter int unsigned NTERM    = 5,
   parameter int unsigned STATE_W  = 8,
   parameter int unsigned ACC_W    = 10,
   parameter bit          SATURATE = 1'b1
) (
   input  logic [PS_W-1:0]    terms [NTERM],
   input  logic [STATE_W-1:0] bias,
   output logic [STATE_W-1:0] next_state
);
   localparam logic signed [ACC_W-1:0] SMAX =
      {{(ACC_W-STATE_W+1){1'b0}}, {(STATE_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] SMIN =
      {{(ACC_W-STATE_W+1){1'b1}}, {(STATE_W-1){1'b0}}};

   logic signed [ACC_W-1:0] total;

   always_comb begin
      total = {{(ACC_W-STATE_W){bias[STATE_W-1]}}, bias};
      for (int k = 0; k < int'(NTERM); k++)
         total = total + {{(ACC_W-PS_W){terms[k][PS_W-1]}}, terms[k]};
   end

   if (SATURATE) begin : g_sat
      always_comb begin
         if (total > SMAX)      next_state = SMAX[STATE_W-1:0];
         else if (total < SMIN) next_state = SMIN[STATE_W-1:0];
         else                   next_state = total[STATE_W-1:0];
      end
   end else begin : g_wrap
      assign next_state = total[STATE_W-1:0];
   end
endmodule

// File: rtl/cnn_pe.sv
module cnn_pe
   import cnn_pe_pkg::*;
#(
   parameter int unsigned COEF_W   = 4,
   parameter int unsigned STATE_W  = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pix_in,
   input  logic [NUM_NBR-1:0]  nbr_y,
   input  logic [NUM_NBR-1:0]  nbr_u,
   input  logic [NUM_NBR-1:0]  edge_mask,
   input  logic                bnd_val,
   input  logic [COEF_W-1:0]   tmpl_a,
   input  logic [COEF_W-1:0]   tmpl_b,
   input  logic [STATE_W-1:0]  bias,
   input  logic                gen_en,
   input  logic                acc_en,
   input  logic                out_en,
   output logic                y_out,
   output logic [STATE_W-1:0]  state_out
);
   localparam int unsigned PS_W   = COEF_W + 2;
   localparam int unsigned SUM_W  = PS_W + $clog2(NUM_SLOTS);
   localparam int unsigned ACC_W  = ((SUM_W > STATE_W) ? SUM_W : STATE_W) + 1;
   localparam int unsigned SLOT_W = SLOT_IDX_W;
   localparam logic [SLOT_W-1:0] SELF_SLOT = SLOT_W'(NUM_SLOTS - 1);

   if (COEF_W < 2) begin : g_bad_coef
      $error("cnn_pe: COEF_W must be at least 2");
   end
   if (STATE_W < 2) begin : g_bad_state
      $error("cnn_pe: STATE_W must be at least 2");
   end

   logic [SLOT_W-1:0]  slot;
   logic               gen_take, acc_take, out_take;
   logic               y_sel, u_sel;
   logic [PS_W-1:0]    ps_now;
   logic [PS_W-1:0]    ps_q [NUM_SLOTS];
   logic [STATE_W-1:0] state_nxt;
   logic [STATE_W-1:0] state_q;
   logic               y_q;

   cnn_pe_seq #(.SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .gen_en(gen_en), .acc_en(acc_en), .out_en(out_en),
      .slot(slot), .gen_take(gen_take), .acc_take(acc_take), .out_take(out_take)
   );

   always_comb begin
      if (slot == SELF_SLOT) begin
         y_sel = y_q;
         u_sel = pix_in;
      end else begin
         y_sel = edge_mask[slot[1:0]] ? bnd_val : nbr_y[slot[1:0]];
         u_sel = edge_mask[slot[1:0]] ? bnd_val : nbr_u[slot[1:0]];
      end
   end

   cnn_pe_psum #(.COEF_W(COEF_W), .PS_W(PS_W)) u_psum (
      .coef_a(tmpl_a), .coef_b(tmpl_b), .y_bit(y_sel), .u_bit(u_sel), .psum(ps_now)
   );

   for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                                 ps_q[gi] <= '0;
         else if (gen_take && slot == SLOT_W'(gi))   ps_q[gi] <= ps_now;
      end
   end

   cnn_pe_acc #(
      .PS_W(PS_W), .NTERM(NUM_SLOTS), .STATE_W(STATE_W),
      .ACC_W(ACC_W), .SATURATE(SATURATE)
   ) u_acc (
      .terms(ps_q), .bias(bias), .next_state(state_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= '0;
         y_q     <= 1'b0;
      end else begin
         if (acc_take) state_q <= state_nxt;
         if (out_take) y_q     <= state_q[STATE_W-1];
      end
   end

   assign state_out = state_q;
   assign y_out     = y_q;
endmodule

// File: rtl/cnn_pe_chk.sv
module cnn_pe_chk #(
   parameter int unsigned STATE_W = 8,
   parameter int unsigned SLOT_W  = 3,
   parameter int unsigned LAST    = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               acc_en,
   input logic               gen_take,
   input logic               acc_take,
   input logic               out_take,
   input logic [SLOT_W-1:0]  slot,
   input logic               y_out,
   input logic [STATE_W-1:0] state_out
);
   // R10
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gen_take, acc_take, out_take}));

   // R5
   state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(acc_take) |-> $stable(state_out));

   // R8
   y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(out_take) |-> $stable(y_out));

   // R8
   y_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_take |=> (y_out == $past(state_out[STATE_W-1])));

   // R7
   acc_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_take) |=> $stable(state_out));

   // R3
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_take && slot != SLOT_W'(LAST)) |=> (slot == $past(slot) + 1'b1));
endmodule

bind cnn_pe cnn_pe_chk #(
   .STATE_W(STATE_W), .SLOT_W(SLOT_W), .LAST(NUM_SLOTS - 1)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_en(acc_en),
   .gen_take(gen_take), .acc_take(acc_take), .out_take(out_take),
   .slot(slot), .y_out(y_out), .state_out(state_out)
);

// File: tb/cnn_pe_tb.sv
module cnn_pe_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pix_in = 1'b0;
   logic [3:0] nbr_y = '0, nbr_u = '0, edge_mask = '0;
   logic       bnd_val = 1'b0;
   logic [3:0] tmpl_a = '0, tmpl_b = '0;
   logic [7:0] bias = '0;
   logic       gen_en = 1'b0, acc_en = 1'b0, out_en = 1'b0;
   logic       y_out;
   logic [7:0] state_out;

   int nchk = 0, nerr = 0;
   int exp_state = 0;
   int exp_y = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cnn_pe u_dut (
      .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .nbr_y(nbr_y), .nbr_u(nbr_u),
      .edge_mask(edge_mask), .bnd_val(bnd_val), .tmpl_a(tmpl_a), .tmpl_b(tmpl_b),
      .bias(bias), .gen_en(gen_en), .acc_en(acc_en), .out_en(out_en),
      .y_out(y_out), .state_out(state_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int pm(input logic b);
      return b ? -1 : 1;
   endfunction

   function automatic int model(input int aa[5], input int bb[5], input int cb);
      int s = cb;
      for (int k = 0; k < 4; k++) begin
         logic ye = edge_mask[k] ? bnd_val : nbr_y[k];
         logic ue = edge_mask[k] ? bnd_val : nbr_u[k];
         s += aa[k] * pm(ye) + bb[k] * pm(ue);
      end
      s += aa[4] * pm(logic'(exp_y)) + bb[4] * pm(pix_in);
      if (s > 127) s = 127;
      if (s < -128) s = -128;
      return s;
   endfunction

   task automatic pulse_gen(input int a, input int b);
      @(negedge clk);
      tmpl_a = 4'(a); tmpl_b = 4'(b); gen_en = 1'b1;
      @(negedge clk);
      gen_en = 1'b0; tmpl_a = 4'(-a); tmpl_b = 4'(-b);
   endtask

   task automatic pulse_acc(input int cb);
      @(negedge clk);
      bias = 8'(cb); acc_en = 1'b1;
      @(negedge clk);
      acc_en = 1'b0;
   endtask

   task automatic pulse_out();
      @(negedge clk);
      out_en = 1'b1;
      @(negedge clk);
      out_en = 1'b0;
   endtask

   task automatic run_iter(input string tag, input int aa[5], input int bb[5], input int cb);
      int e = model(aa, bb, cb);
      for (int k = 0; k < 5; k++) pulse_gen(aa[k], bb[k]);
      pulse_acc(cb);
      chk({tag, " state"}, int'($signed(state_out)), e);
      exp_state = e;
      pulse_out();
      exp_y = (e < 0) ? 1 : 0;
      chk({tag, " output R8"}, int'(y_out), exp_y);
   endtask

   task automatic t_reset();
      chk("R1 reset state", int'($signed(state_out)), 0);
      chk("R1 reset output", int'(y_out), 0);
   endtask

   task automatic t_basic();
      nbr_y = 4'b0000; nbr_u = 4'b0000; pix_in = 1'b0;
      run_iter("R2 R3 all plus", '{1, 2, 3, -1, 2}, '{0, 1, -2, 1, 1}, 5);
      nbr_y = 4'b0101; nbr_u = 4'b1100; pix_in = 1'b1;
      run_iter("R3 order", '{1, 2, 4, -8, 0}, '{3, -1, 0, 2, 1}, -3);
   endtask

   task automatic t_sat();
      nbr_y = 4'b0000; nbr_u = 4'b0000; pix_in = 1'b0; exp_y = int'(y_out);
      run_iter("R6 high", '{7, 7, 7, 7, 0}, '{7, 7, 7, 7, 7}, 127);
      nbr_y = 4'b0000; nbr_u = 4'b0000;
      run_iter("R6 low", '{-8, -8, -8, -8, 0}, '{-8, -8, -8, -8, -8}, -128);
   endtask

   task automatic t_edge();
      nbr_y = 4'b0000; nbr_u = 4'b0000; pix_in = 1'b0;
      edge_mask = 4'b1010; bnd_val = 1'b1;
      run_iter("R4 mask bnd1", '{1, 3, 1, 5, 0}, '{1, 2, 1, 2, 0}, 0);
      edge_mask = 4'b0101; bnd_val = 1'b0; nbr_y = 4'b1111; nbr_u = 4'b1111;
      run_iter("R4 mask bnd0", '{4, 1, 4, 1, 0}, '{2, 1, 2, 1, 0}, 0);
      edge_mask = 4'b0000;
   endtask

   task automatic t_self();
      nbr_y = 4'b0000; nbr_u = 4'b0000; pix_in = 1'b0;
      run_iter("R9 prep neg", '{0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0}, -1);
      run_iter("R9 own y", '{0, 0, 0, 0, 5}, '{0, 0, 0, 0, 0}, 0);
      pix_in = 1'b1;
      run_iter("R9 own pix", '{0, 0, 0, 0, 0}, '{0, 0, 0, 0, 3}, 1);
      pix_in = 1'b0;
   endtask

   task automatic t_ignore();
      int aa[5] = '{2, -3, 1, 1, 0};
      int bb[5] = '{1, 1, -1, 0, 2};
      int e;
      nbr_y = 4'b0011; nbr_u = 4'b0110; pix_in = 1'b0;
      e = model(aa, bb, 9);
      pulse_gen(aa[0], bb[0]);
      pulse_gen(aa[1], bb[1]);
      pulse_acc(100);
      chk("R7 acc during gen", int'($signed(state_out)), exp_state);
      pulse_out();
      chk("R7 out during gen", int'(y_out), exp_y);
      for (int k = 2; k < 5; k++) pulse_gen(aa[k], bb[k]);
      pulse_gen(7, 7);
      pulse_out();
      chk("R7 out before acc", int'(y_out), exp_y);
      pulse_acc(9);
      chk("R7 sixth gen ignored", int'($signed(state_out)), e);
      pulse_acc(-50);
      chk("R10 second acc ignored", int'($signed(state_out)), e);
      exp_state = e;
      pulse_out();
      exp_y = (e < 0) ? 1 : 0;
      chk("R8 output after ignores", int'(y_out), exp_y);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_sat();
      t_edge();
      t_self();
      t_ignore();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule